// File: doc/BRIEF.md
# Flash command launch controller

This block is the register front end of a nonvolatile memory controller. Software writes three registers through one write port: a clock divider that sets the program/erase time base, a command register, and a status register. The divider holds the divide value that brings the bus clock down to a time base of about 1 MHz. A sticky loaded flag shows whether the divider has been written since reset. The time-base counter stays idle until that first write and then emits one-cycle ticks.

A command is launched when software writes 1 to the command-complete bit of the status register. Several conditions can stop the launch before anything runs:
- The launch is ignored if either error flag is set or a command is already running.
- A program or erase request is refused and raises the access-error flag when the divider has never been loaded.
- An illegal command class also raises the access-error flag.
- A program or erase aimed at a protected sector raises the protection-violation flag.

A valid command clears command-complete and starts a stub execution engine. Program and erase take a fixed number of time-base ticks. Verify takes a fixed number of bus cycles and does not need the divider. Command-complete rises again when the engine finishes.

Top module: `fcl_launch_ctrl`

## Requirements
- R1: After reset, the outputs hold these values: div_loaded_o=0, fdiv_o=0, tick_o=0, cmd_o=0, cmd_done_o=1, acc_err_o=0, prot_err_o=0.
- R2: A write with wr_sel_i=0 while div_loaded_o=0 stores wr_data_i[FDIV_W-1:0] in fdiv_o and sets div_loaded_o. Once div_loaded_o=1, further divider writes leave fdiv_o unchanged until reset.
- R3: tick_o never rises while div_loaded_o=0. Once the divider is loaded, tick_o is a pulse of one cycle every fdiv_o+1 cycles.
- R4: A launch is a write with wr_sel_i=1 and bit 7 set, made while cmd_done_o=1 and both error flags are 0. Command classes are cmd_o[1:0]: 00 verify, 01 program, 10 erase, 11 illegal. A valid launch of program or erase clears cmd_done_o for a span that contains exactly ENG_TICKS ticks.
- R5: Launching program or erase while div_loaded_o=0 sets acc_err_o and leaves cmd_done_o=1.
- R6: Launching class 11 sets acc_err_o and leaves cmd_done_o=1.
- R7: The target sector is cmd_o[7:2]. Launching program or erase with div_loaded_o=1 and sector >= PROT_FROM sets prot_err_o and leaves cmd_done_o=1. Verify is never refused for its sector.
- R8: A launch write made while acc_err_o or prot_err_o is 1 has no effect: cmd_done_o stays 1 and neither flag changes.
- R9: In a status write, bit 5 = 1 clears acc_err_o and bit 4 = 1 clears prot_err_o. A 0 in those bits leaves the flag unchanged.
- R10: While cmd_done_o=0, launch writes and command-register writes (wr_sel_i=2) are ignored. cmd_o stays as it was and the running command ends on its normal schedule.
- R11: A verify launch runs with or without a loaded divider and holds cmd_done_o low for exactly VERIFY_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 divider, 1 status, 2 command |
| wr_data_i | input | 8 | Write data |
| fdiv_o | output | FDIV_W | Stored divide value |
| div_loaded_o | output | 1 | Divider written since reset |
| tick_o | output | 1 | Time-base tick |
| cmd_o | output | 8 | Command register: class [1:0], sector [7:2] |
| cmd_done_o | output | 1 | Command-complete flag |
| acc_err_o | output | 1 | Access-error flag |
| prot_err_o | output | 1 | Protection-violation flag |

## Verification
The bench sweeps every divide value from 0 to 7, with a fresh reset for each value. For each one it measures the tick period, counts the ticks and cycles while a program runs, and tries a second divider write. This separates off-by-one errors in the reload from errors in engine pacing and from a write-once flag that does not hold. The launch is tried under each refusal condition:
- a divider that was never loaded;
- an illegal class;
- sector 48 against sector 47 for erase;
- the top sector for program and for verify;
- an error flag left set;
- a command already busy.

For each case the bench checks which flag moves and whether command-complete falls. Each error flag is also written with 0 and then with 1, to check that only a 1 clears it.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  localparam int DATA_W = 8;

  localparam int ST_DONE_BIT = 7;
  localparam int ST_ACC_BIT  = 5;
  localparam int ST_PROT_BIT = 4;

  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    CLS_VERIFY = 2'b00,
    CLS_PROG   = 2'b01,
    CLS_ERASE  = 2'b10,
    CLS_BAD    = 2'b11
  } cmd_cls_e;

  typedef enum logic [1:0] {
    GATE_IGNORE,
    GATE_ACC,
    GATE_PROT,
    GATE_RUN
  } gate_e;
endpackage

// File: rtl/fcl_timebase.sv
module fcl_timebase #(
  parameter int FDIV_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [FDIV_W-1:0] load_val_i,
  input  logic              loaded_i,
  input  logic [FDIV_W-1:0] fdiv_i,
  output logic              tick_o
);
  logic [FDIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (loaded_i) begin
      cnt_q <= (cnt_q == '0) ? fdiv_i : cnt_q - 1'b1;
    end
  end

  assign tick_o = loaded_i && (cnt_q == '0);
endmodule

// File: rtl/fcl_launch_gate.sv
module fcl_launch_gate
  import fcl_pkg::*;
#(
  parameter int SECT_W    = 6,
  parameter int PROT_FROM = 48
) (
  input  logic              strike_i,
  input  logic              done_i,
  input  logic              acc_i,
  input  logic              prot_i,
  input  logic              loaded_i,
  input  cmd_cls_e          cls_i,
  input  logic [SECT_W-1:0] sector_i,
  output gate_e             verdict_o
);
  logic pe_cls;
  logic in_prot;

  assign pe_cls  = (cls_i == CLS_PROG) || (cls_i == CLS_ERASE);
  assign in_prot = {1'b0, sector_i} >= (SECT_W+1)'(PROT_FROM);

  // priority: gating, illegal class, divider missing, protection
  always_comb begin
    if (!strike_i || !done_i || acc_i || prot_i) verdict_o = GATE_IGNORE;
    else if (cls_i == CLS_BAD)                   verdict_o = GATE_ACC;
    else if (pe_cls && !loaded_i)                verdict_o = GATE_ACC;
    else if (pe_cls && in_prot)                  verdict_o = GATE_PROT;
    else                                         verdict_o = GATE_RUN;
  end
endmodule

// File: rtl/fcl_engine_stub.sv
module fcl_engine_stub #(
  parameter int ENG_TICKS     = 3,
  parameter int VERIFY_CYCLES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic is_verify_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int MAX_N = (ENG_TICKS > VERIFY_CYCLES) ? ENG_TICKS : VERIFY_CYCLES;
  localparam int CNT_W = $clog2(MAX_N + 1);

  logic             busy_q;
  logic             verify_q;
  logic [CNT_W-1:0] rem_q;
  logic             step;

  // verify paces on bus cycles, program/erase on time-base ticks
  assign step   = verify_q ? 1'b1 : tick_i;
  assign done_o = busy_q && step && (rem_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      verify_q <= 1'b0;
      rem_q    <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      verify_q <= is_verify_i;
      rem_q    <= is_verify_i ? CNT_W'(VERIFY_CYCLES) : CNT_W'(ENG_TICKS);
    end else if (busy_q && step) begin
      if (rem_q == CNT_W'(1)) busy_q <= 1'b0;
      rem_q <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/fcl_launch_ctrl.sv
module fcl_launch_ctrl
  import fcl_pkg::*;
#(
  parameter int FDIV_W        = 6,
  parameter int ENG_TICKS     = 3,
  parameter int VERIFY_CYCLES = 5,
  parameter int PROT_FROM     = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [FDIV_W-1:0] fdiv_o,
  output logic              div_loaded_o,
  output logic              tick_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic              cmd_done_o,
  output logic              acc_err_o,
  output logic              prot_err_o
);
  localparam int SECT_W = DATA_W - 2;

  logic [FDIV_W-1:0] fdiv_q;
  logic              loaded_q;
  logic [DATA_W-1:0] cmd_q;
  logic              done_q, acc_q, prot_q;
  logic              wr_div, wr_stat, wr_cmd, div_load;
  logic              tick, eng_done;
  cmd_cls_e          cls;
  gate_e             verdict;

  assign wr_div   = wr_en_i && (wr_sel_i == SEL_DIV);
  assign wr_stat  = wr_en_i && (wr_sel_i == SEL_STAT);
  assign wr_cmd   = wr_en_i && (wr_sel_i == SEL_CMD);
  assign div_load = wr_div && !loaded_q;
  assign cls      = cmd_cls_e'(cmd_q[1:0]);

  fcl_timebase #(.FDIV_W(FDIV_W)) u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (div_load),
    .load_val_i (wr_data_i[FDIV_W-1:0]),
    .loaded_i   (loaded_q),
    .fdiv_i     (fdiv_q),
    .tick_o     (tick)
  );

  fcl_launch_gate #(.SECT_W(SECT_W), .PROT_FROM(PROT_FROM)) u_gate (
    .strike_i  (wr_stat && wr_data_i[ST_DONE_BIT]),
    .done_i    (done_q),
    .acc_i     (acc_q),
    .prot_i    (prot_q),
    .loaded_i  (loaded_q),
    .cls_i     (cls),
    .sector_i  (cmd_q[DATA_W-1:2]),
    .verdict_o (verdict)
  );

  fcl_engine_stub #(.ENG_TICKS(ENG_TICKS), .VERIFY_CYCLES(VERIFY_CYCLES)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (verdict == GATE_RUN),
    .is_verify_i (cls == CLS_VERIFY),
    .tick_i      (tick),
    .done_o      (eng_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fdiv_q   <= '0;
      loaded_q <= 1'b0;
    end else if (div_load) begin
      fdiv_q   <= wr_data_i[FDIV_W-1:0];
      loaded_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cmd_q <= '0;
    else if (wr_cmd && done_q) cmd_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b1;
      acc_q  <= 1'b0;
      prot_q <= 1'b0;
    end else begin
      if (verdict == GATE_RUN) done_q <= 1'b0;
      else if (eng_done)       done_q <= 1'b1;

      if (verdict == GATE_ACC)                   acc_q <= 1'b1;
      else if (wr_stat && wr_data_i[ST_ACC_BIT]) acc_q <= 1'b0;

      if (verdict == GATE_PROT)                   prot_q <= 1'b1;
      else if (wr_stat && wr_data_i[ST_PROT_BIT]) prot_q <= 1'b0;
    end
  end

  assign fdiv_o       = fdiv_q;
  assign div_loaded_o = loaded_q;
  assign tick_o       = tick;
  assign cmd_o        = cmd_q;
  assign cmd_done_o   = done_q;
  assign acc_err_o    = acc_q;
  assign prot_err_o   = prot_q;
endmodule

// File: rtl/fcl_launch_ctrl_chk.sv
module fcl_launch_ctrl_chk #(
  parameter int FDIV_W    = 6,
  parameter int PROT_FROM = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic              strike_i,
  input logic              acc_clr_i,
  input logic [FDIV_W-1:0] fdiv_o,
  input logic              div_loaded_o,
  input logic              tick_o,
  input logic [7:0]        cmd_o,
  input logic              cmd_done_o,
  input logic              acc_err_o,
  input logic              prot_err_o
);
  logic st_wr, try_clean, pe_cls, low_sect;

  assign st_wr     = wr_en_i && (wr_sel_i == 2'd1);
  assign try_clean = st_wr && strike_i && cmd_done_o && !acc_err_o && !prot_err_o;
  assign pe_cls    = (cmd_o[1:0] == 2'b01) || (cmd_o[1:0] == 2'b10);
  assign low_sect  = {26'd0, cmd_o[7:2]} < PROT_FROM;

  a_r2_div_write_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_loaded_o |=> div_loaded_o && $stable(fdiv_o));

  a_r3_no_tick_unloaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_loaded_o |-> !tick_o);

  a_r3_tick_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && fdiv_o != '0) |=> !tick_o);

  a_r4_launch_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (try_clean && (cmd_o[1:0] == 2'b00 || (pe_cls && div_loaded_o && low_sect))) |=> !cmd_done_o);

  a_r5_unloaded_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (try_clean && pe_cls && !div_loaded_o) |=> acc_err_o && cmd_done_o);

  a_r6_bad_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (try_clean && cmd_o[1:0] == 2'b11) |=> acc_err_o && cmd_done_o);

  a_r7_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (try_clean && pe_cls && div_loaded_o && !low_sect) |=> prot_err_o && cmd_done_o);

  a_r8_err_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && strike_i && cmd_done_o && (acc_err_o || prot_err_o)) |=> cmd_done_o);

  a_r9_acc_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_err_o && !(st_wr && acc_clr_i)) |=> acc_err_o);

  a_r10_cmd_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_done_o && wr_en_i && wr_sel_i == 2'd2) |=> $stable(cmd_o));
endmodule

bind fcl_launch_ctrl fcl_launch_ctrl_chk #(.FDIV_W(FDIV_W), .PROT_FROM(PROT_FROM)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .strike_i     (wr_data_i[7]),
  .acc_clr_i    (wr_data_i[5]),
  .fdiv_o       (fdiv_o),
  .div_loaded_o (div_loaded_o),
  .tick_o       (tick_o),
  .cmd_o        (cmd_o),
  .cmd_done_o   (cmd_done_o),
  .acc_err_o    (acc_err_o),
  .prot_err_o   (prot_err_o)
);

// File: tb/fcl_launch_ctrl_tb.sv
module fcl_launch_ctrl_tb;
  localparam int FDIV_W = 6;
  localparam int ENG_T  = 3;
  localparam int VER_C  = 5;
  localparam int PROT   = 48;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [FDIV_W-1:0] fdiv;
  logic div_loaded, tick, cmd_done, acc_err, prot_err;
  logic [7:0] cmd;

  int checks = 0;
  int fails = 0;
  int low_tot = 0;
  int tick_low_tot = 0;
  int tick_seen_unloaded = 0;

  always #4 clk = ~clk;

  fcl_launch_ctrl #(.FDIV_W(FDIV_W), .ENG_TICKS(ENG_T), .VERIFY_CYCLES(VER_C), .PROT_FROM(PROT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .fdiv_o(fdiv), .div_loaded_o(div_loaded), .tick_o(tick), .cmd_o(cmd),
    .cmd_done_o(cmd_done), .acc_err_o(acc_err), .prot_err_o(prot_err)
  );

  always @(negedge clk) begin
    if (rst_ni && !cmd_done) begin
      low_tot = low_tot + 1;
      if (tick) tick_low_tot = tick_low_tot + 1;
    end
    if (rst_ni && !div_loaded && tick) tick_seen_unloaded = tick_seen_unloaded + 1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !cmd_done; i++) @(negedge clk);
  endtask

  task automatic tick_period(output int p);
    int i;
    p = 0;
    for (i = 0; i < 200 && !tick; i++) @(negedge clk);
    do begin
      @(negedge clk);
      p = p + 1;
    end while (!tick && p < 200);
  endtask

  initial begin
    int l0, t0, p;
    do_reset();

    // R1 reset values
    chk("R1 loaded", div_loaded, 0);
    chk("R1 fdiv", fdiv, 0);
    chk("R1 tick", tick, 0);
    chk("R1 cmd", cmd, 0);
    chk("R1 done", cmd_done, 1);
    chk("R1 acc", acc_err, 0);
    chk("R1 prot", prot_err, 0);

    // R11 verify with no divider
    wr(2'd2, 8'h00);
    l0 = low_tot;
    wr(2'd1, 8'h80);
    chk("R11 done falls", cmd_done, 0);
    wait_done();
    chk("R11 verify cycles", low_tot - l0, VER_C);

    // R5 program refused before divider load
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h80);
    chk("R5 acc set", acc_err, 1);
    chk("R5 done held", cmd_done, 1);

    // R8 launch with acc set is ignored
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h80);
    chk("R8 done held", cmd_done, 1);
    chk("R8 acc kept", acc_err, 1);

    // R9 write of 0 keeps flag, 1 clears
    wr(2'd1, 8'h00);
    chk("R9 acc zero-write", acc_err, 1);
    wr(2'd1, 8'h20);
    chk("R9 acc cleared", acc_err, 0);

    // R6 illegal class
    wr(2'd2, 8'h03);
    wr(2'd1, 8'h80);
    chk("R6 acc set", acc_err, 1);
    chk("R6 done held", cmd_done, 1);
    wr(2'd1, 8'h20);
    chk("R3 no tick while unloaded", tick_seen_unloaded, 0);

    // R2 divider load and write-once
    wr(2'd0, 8'd5);
    chk("R2 loaded", div_loaded, 1);
    chk("R2 fdiv", fdiv, 5);
    wr(2'd0, 8'd9);
    chk("R2 write-once", fdiv, 5);

    // R7 protected sector, boundary at PROT
    wr(2'd2, 8'((PROT << 2) | 2));
    wr(2'd1, 8'h80);
    chk("R7 prot set", prot_err, 1);
    chk("R7 done held", cmd_done, 1);
    chk("R7 acc clear", acc_err, 0);
    wr(2'd1, 8'h00);
    chk("R9 prot zero-write", prot_err, 1);
    wr(2'd1, 8'h10);
    chk("R9 prot cleared", prot_err, 0);
    wr(2'd2, 8'hFD);
    wr(2'd1, 8'h80);
    chk("R7 program top sector", prot_err, 1);
    wr(2'd1, 8'h10);

    // R7 verify on protected sector still runs
    wr(2'd2, 8'hFC);
    l0 = low_tot;
    wr(2'd1, 8'h80);
    wait_done();
    chk("R7 verify top sector cycles", low_tot - l0, VER_C);
    chk("R7 verify no prot", prot_err, 0);

    // R4 erase just below the boundary
    wr(2'd2, 8'(((PROT - 1) << 2) | 2));
    t0 = tick_low_tot;
    wr(2'd1, 8'h80);
    chk("R4 erase started", cmd_done, 0);
    wait_done();
    chk("R4 erase ticks", tick_low_tot - t0, ENG_T);

    // R10 writes while busy
    wr(2'd2, 8'h01);
    t0 = tick_low_tot;
    wr(2'd1, 8'h80);
    wr(2'd2, 8'h02);
    chk("R10 cmd frozen", cmd, 8'h01);
    wr(2'd1, 8'h80);
    chk("R10 still busy", cmd_done, 0);
    wait_done();
    chk("R10 tick count", tick_low_tot - t0, ENG_T);

    // sweep of divide values: R3 period, R4 pacing, R2 write-once
    for (int d = 0; d < 8; d++) begin
      do_reset();
      wr(2'd0, 8'(d));
      tick_period(p);
      chk("R3 period", p, d + 1);
      tick_period(p);
      chk("R3 period again", p, d + 1);
      wr(2'd0, 8'(d ^ 3));
      chk("R2 sweep write-once", fdiv, d);
      wr(2'd2, 8'h01);
      l0 = low_tot; t0 = tick_low_tot;
      wr(2'd1, 8'h80);
      wait_done();
      chk("R4 sweep ticks", tick_low_tot - t0, ENG_T);
      chk("R4 sweep span max", int'((low_tot - l0) <= ENG_T * (d + 1)), 1);
      chk("R4 sweep span min", int'((low_tot - l0) >= (ENG_T - 1) * (d + 1) + 1), 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule